// File: doc/BRIEF.md
# Rotate-Through-Carry Shift Register

This block is a clocked 8-bit shift unit with a one-bit carry flag. On every rising clock edge a two-bit operation select picks one of four actions: keep the word, rotate it right, rotate it left, or take a new word from the parallel input. A separate carry-mode bit decides how a rotation behaves. With carry mode off, the rotation is a plain circular rotate of the 8-bit word. With carry mode on, the word and the carry flag form a 9-bit ring.

In a rotate through carry, the external carry input enters the vacated end of the word. The bit that leaves the other end is captured in the carry flag, which drives the carry output. Any other operation leaves the carry flag unchanged.

The block is meant to sit behind plain synchronous control signals. A controller can use it for serial bit extraction, multi-word rotations chained through the carry, or simple bit-pattern generation.

Top module: `rot_carry_shifter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the next state of `dout` is 8'h00 and the next state of `carry_out` is 0. The reset is synchronous and active high.
- R2: With `sel` = 2'd0 (hold), `dout` and `carry_out` keep their values across the edge.
- R3: With `sel` = 2'd3 (load), `dout` takes `din` and `carry_out` keeps its value, whatever `thru_carry` is.
- R4: With `sel` = 2'd1 and `thru_carry` = 0, `dout` becomes {dout[0], dout[7:1]} (plain rotate right) and `carry_out` keeps its value.
- R5: With `sel` = 2'd2 and `thru_carry` = 0, `dout` becomes {dout[6:0], dout[7]} (plain rotate left) and `carry_out` keeps its value.
- R6: With `sel` = 2'd1 and `thru_carry` = 1, `dout` becomes {carry_in, dout[7:1]} and `carry_out` becomes the old dout[0].
- R7: With `sel` = 2'd2 and `thru_carry` = 1, `dout` becomes {dout[6:0], carry_in} and `carry_out` becomes the old dout[7].
- R8: `carry_in` has no effect on `dout` or `carry_out` unless a rotate through carry is selected. `din` has no effect unless a load is selected.
- R9: Eight plain rotates in one direction return the original word. Nine rotates through carry, with `carry_in` fed from the previous `carry_out`, return both the original word and the original carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Operation: 0 hold, 1 rotate right, 2 rotate left, 3 load |
| thru_carry | input | 1 | 1 makes rotations pass through the carry flag |
| carry_in | input | 1 | Bit entering the word in a rotate through carry |
| din | input | 8 | Parallel load data |
| dout | output | 8 | Registered word |
| carry_out | output | 1 | Registered carry flag |

## Verification
Two cases are the hardest to reach from the ports. The first is closing the 9-bit ring: the carry flag changes only during a rotate through carry, so the stimulus must load a known word and then feed `carry_out` back into `carry_in` for nine edges. Only after those nine edges can the word and the flag be compared with their starting values. The second is showing that the carry flag survives loads, holds and plain rotates. To do this, the directed tasks first set the flag to a known non-zero value with a rotate through carry, then apply the other operations with `carry_in` driven to the opposite value. A final task drives mixed random operations against a bench model.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Operation select codes as seen on the sel port
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ROR  = 2'd1,
        OP_ROL  = 2'd2,
        OP_LOAD = 2'd3
    } op_e;

    // Internal action after combining sel with the carry-mode bit
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_LOAD = 3'd1,
        ACT_ROR  = 3'd2,
        ACT_ROL  = 3'd3,
        ACT_RCR  = 3'd4,
        ACT_RCL  = 3'd5
    } act_e;

    typedef struct packed {
        act_e act;        // what the word register does
        logic carry_we;   // carry flag captures the bit that leaves
        logic word_we;    // word register changes
    } ctl_t;

    function automatic ctl_t decode_op(op_e op, logic thru);
        ctl_t c;
        c.act      = ACT_HOLD;
        c.carry_we = 1'b0;
        c.word_we  = 1'b0;
        unique case (op)
            OP_HOLD: c.act = ACT_HOLD;
            OP_LOAD: begin c.act = ACT_LOAD; c.word_we = 1'b1; end
            OP_ROR: begin
                c.act      = thru ? ACT_RCR : ACT_ROR;
                c.carry_we = thru;
                c.word_we  = 1'b1;
            end
            OP_ROL: begin
                c.act      = thru ? ACT_RCL : ACT_ROL;
                c.carry_we = thru;
                c.word_we  = 1'b1;
            end
            default: c.act = ACT_HOLD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rcs_decode.sv
module rcs_decode
    import rcs_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       thru_carry,
    output ctl_t       ctl
);
    always_comb begin
        ctl = decode_op(op_e'(sel), thru_carry);
    end

    // R8: the carry flag is written only by a rotation
    always_comb begin
        a_r8_carry_we_only_rotate: assert (!(ctl.carry_we && !ctl.word_we));
    end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
    import rcs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    input  logic             c,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] din,
    input  ctl_t             ctl,
    output logic [WIDTH-1:0] q_nxt,
    output logic             c_nxt
);
    localparam int MSB = WIDTH - 1;

    logic fill_r;   // bit entering the top on a right rotation
    logic fill_l;   // bit entering the bottom on a left rotation
    logic [WIDTH-1:0] ror_v;
    logic [WIDTH-1:0] rol_v;

    always_comb begin
        fill_r = (ctl.act == ACT_RCR) ? carry_in : q[0];
        fill_l = (ctl.act == ACT_RCL) ? carry_in : q[MSB];
    end

    // One neighbour-select cell per bit for each direction
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == MSB) begin : g_top
            assign ror_v[i] = fill_r;
        end else begin : g_mid_r
            assign ror_v[i] = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign rol_v[i] = fill_l;
        end else begin : g_mid_l
            assign rol_v[i] = q[i-1];
        end
    end

    always_comb begin
        unique case (ctl.act)
            ACT_LOAD:         q_nxt = din;
            ACT_ROR, ACT_RCR: q_nxt = ror_v;
            ACT_ROL, ACT_RCL: q_nxt = rol_v;
            default:          q_nxt = q;
        endcase
    end

    always_comb begin
        if (ctl.carry_we) begin
            c_nxt = (ctl.act == ACT_RCR) ? q[0] : q[MSB];
        end else begin
            c_nxt = c;
        end
    end
endmodule

// File: rtl/rcs_state.sv
module rcs_state #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] q_nxt,
    input  logic             c_nxt,
    output logic [WIDTH-1:0] q,
    output logic             c
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
            c <= 1'b0;
        end else begin
            q <= q_nxt;
            c <= c_nxt;
        end
    end
endmodule

// File: rtl/rot_carry_shifter.sv
module rot_carry_shifter
    import rcs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel,
    input  logic             thru_carry,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    ctl_t             ctl;
    logic [WIDTH-1:0] q_nxt;
    logic             c_nxt;

    rcs_decode u_dec (
        .sel        (sel),
        .thru_carry (thru_carry),
        .ctl        (ctl)
    );

    rcs_datapath #(.WIDTH(WIDTH)) u_dp (
        .q        (dout),
        .c        (carry_out),
        .carry_in (carry_in),
        .din      (din),
        .ctl      (ctl),
        .q_nxt    (q_nxt),
        .c_nxt    (c_nxt)
    );

    rcs_state #(.WIDTH(WIDTH)) u_st (
        .clk   (clk),
        .rst   (rst),
        .q_nxt (q_nxt),
        .c_nxt (c_nxt),
        .q     (dout),
        .c     (carry_out)
    );

    // Port-level behaviour checks
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd0) |=> (dout == $past(dout) && carry_out == $past(carry_out)));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd3) |=> (dout == $past(din) && carry_out == $past(carry_out)));

    a_r4_ror_plain: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd1 && !thru_carry) |=>
        (dout == {$past(dout[0]), $past(dout[MSB:1])} && carry_out == $past(carry_out)));

    a_r5_rol_plain: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd2 && !thru_carry) |=>
        (dout == {$past(dout[MSB-1:0]), $past(dout[MSB])} && carry_out == $past(carry_out)));

    a_r6_ror_carry: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd1 && thru_carry) |=>
        (dout == {$past(carry_in), $past(dout[MSB:1])} && carry_out == $past(dout[0])));

    a_r7_rol_carry: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd2 && thru_carry) |=>
        (dout == {$past(dout[MSB-1:0]), $past(carry_in)} && carry_out == $past(dout[MSB])));

    a_r8_carry_kept: assert property (@(posedge clk) disable iff (rst)
        (!(thru_carry && (sel == 2'd1 || sel == 2'd2))) |=> $stable(carry_out));
endmodule

// File: tb/rot_carry_shifter_tb_top.sv
module rot_carry_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sel;
    logic       thru_carry;
    logic       carry_in;
    logic [7:0] din;
    logic [7:0] dout;
    logic       carry_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [7:0] exp_q;
    logic       exp_c;

    always #10 clk = ~clk;   // 50 MHz

    rot_carry_shifter dut_i (
        .clk(clk), .rst(rst), .sel(sel), .thru_carry(thru_carry),
        .carry_in(carry_in), .din(din), .dout(dout), .carry_out(carry_out)
    );

    task automatic check(string req, logic [7:0] got_q, logic got_c,
                         logic [7:0] want_q, logic want_c);
        n_checks++;
        if (got_q !== want_q || got_c !== want_c) begin
            n_fail++;
            $display("FAIL %s: dout=%h carry_out=%b expected dout=%h carry_out=%b",
                     req, got_q, got_c, want_q, want_c);
        end
    endtask

    // Bench model of one edge, written from the requirements
    task automatic model(logic r, logic [1:0] s, logic m, logic ci, logic [7:0] d);
        logic [7:0] q0;
        logic       c0;
        q0 = exp_q;
        c0 = exp_c;
        if (r) begin
            exp_q = 8'h00; exp_c = 1'b0;
        end else begin
            case (s)
                2'd3: exp_q = d;
                2'd1: begin
                    exp_q = {(m ? ci : q0[0]), q0[7:1]};
                    if (m) exp_c = q0[0];
                end
                2'd2: begin
                    exp_q = {q0[6:0], (m ? ci : q0[7])};
                    if (m) exp_c = q0[7];
                end
                default: ;
            endcase
            if (s == 2'd0) begin exp_q = q0; exp_c = c0; end
        end
    endtask

    task automatic step(string req, logic r, logic [1:0] s, logic m,
                        logic ci, logic [7:0] d);
        @(negedge clk);
        rst = r; sel = s; thru_carry = m; carry_in = ci; din = d;
        model(r, s, m, ci, d);
        @(posedge clk);
        #1;
        check(req, dout, carry_out, exp_q, exp_c);
    endtask

    task automatic t_reset;
        step("R1 reset", 1'b1, 2'd0, 1'b0, 1'b0, 8'h00);
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'hFF);
        step("R6 set carry", 1'b0, 2'd1, 1'b1, 1'b0, 8'h00);
        step("R1 reset clears", 1'b1, 2'd3, 1'b1, 1'b1, 8'hFF);
    endtask

    task automatic t_load_hold;
        step("R3 load thru=0", 1'b0, 2'd3, 1'b0, 1'b1, 8'h5A);
        step("R3 load thru=1", 1'b0, 2'd3, 1'b1, 1'b1, 8'hC3);
        step("R2 hold", 1'b0, 2'd0, 1'b1, 1'b1, 8'h00);
        step("R2 hold again", 1'b0, 2'd0, 1'b0, 1'b0, 8'hFF);
    endtask

    task automatic t_plain;
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'h81);
        step("R7 set carry", 1'b0, 2'd2, 1'b1, 1'b0, 8'h00);   // carry <- 1
        step("R4 ror plain", 1'b0, 2'd1, 1'b0, 1'b0, 8'h00);
        step("R4 ror plain", 1'b0, 2'd1, 1'b0, 1'b0, 8'h00);
        step("R5 rol plain", 1'b0, 2'd2, 1'b0, 1'b0, 8'h00);
        step("R5 rol plain", 1'b0, 2'd2, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_carry;
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'h01);
        step("R6 rcr ci=1", 1'b0, 2'd1, 1'b1, 1'b1, 8'h00);
        step("R6 rcr ci=0", 1'b0, 2'd1, 1'b1, 1'b0, 8'h00);
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'h80);
        step("R7 rcl ci=1", 1'b0, 2'd2, 1'b1, 1'b1, 8'h00);
        step("R7 rcl ci=0", 1'b0, 2'd2, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_ignore;
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'h3C);
        step("R8 hold ci=1", 1'b0, 2'd0, 1'b0, 1'b1, 8'hFF);
        step("R8 ror plain ci=1", 1'b0, 2'd1, 1'b0, 1'b1, 8'hFF);
        step("R8 rol plain ci=1", 1'b0, 2'd2, 1'b0, 1'b1, 8'h00);
        step("R8 load ci=1", 1'b0, 2'd3, 1'b0, 1'b1, 8'h96);
    endtask

    task automatic t_ring;
        logic [7:0] q_start;
        logic       c_start;
        step("R3 load", 1'b0, 2'd3, 1'b0, 1'b0, 8'hA5);
        q_start = dout; c_start = carry_out;
        for (int i = 0; i < 8; i++) step("R9 rol 8x", 1'b0, 2'd2, 1'b0, 1'b0, 8'h00);
        check("R9 plain ring", dout, carry_out, q_start, c_start);
        step("R6 set carry", 1'b0, 2'd1, 1'b1, 1'b1, 8'h00);
        q_start = dout; c_start = carry_out;
        for (int i = 0; i < 9; i++) step("R9 rcr 9x", 1'b0, 2'd1, 1'b1, carry_out, 8'h00);
        check("R9 carry ring", dout, carry_out, q_start, c_start);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("R2-R8 mixed", (rv[31:27] == 5'd0), rv[1:0], rv[2], rv[3], rv[11:4]);
        end
    endtask

    initial begin
        rst = 1'b1; sel = 2'd0; thru_carry = 1'b0; carry_in = 1'b0; din = 8'h00;
        exp_q = 8'h00; exp_c = 1'b0;
        t_reset();
        t_load_hold();
        t_plain();
        t_carry();
        t_ignore();
        t_ring();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule